// File: doc/BRIEF.md
# Debug Port Bring-Up Sequencer

This controller brings a serial-wire debug target from an unknown line state to a usable memory-access port. It sits above a wire transaction engine and never touches the wire itself. It hands the engine one request at a time: a line-switch burst, a register read or a register write. It then waits for the engine's completion pulse before it decides the next step.

The sequence starts on its own when reset is released and again on each start command once a run has finished. It sends the line-switch burst, reads and checks the identification value, and requests system and debug power-up, polling until both acknowledges appear. It then runs a debug-reset request/acknowledge/release handshake. Last, it selects the identification bank of the default access port and reads that port's identification word through the posted-read buffer, to confirm the port is a memory-bus port. The block ends with a pass flag or with a code that names the failing step.

Top module: `dbg_bringup_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy_o=1, done_o=0 and a line-switch request is presented (txn_req_o=1, txn_kind_o=0). Kind encoding: 0 line-switch, 1 read, 2 write.
- R2: A request is accepted when txn_done_i is high at a clock edge. Until then txn_req_o, txn_kind_o, txn_ap_o, txn_addr_o and txn_wdata_o hold steady. The next request may appear in the cycle after acceptance.
- R3: Requests are issued in this order: line-switch; debug-port read at address 0x0 (ID); write CTRL/STAT (debug-port address 0x4); polling reads of 0x4; reset write to 0x4; polling reads of 0x4; release write to 0x4; write 0x000000F0 to bank select (debug-port address 0x8); access-port read at 0xC (txn_ap_o=1); debug-port read of the read buffer at 0xC.
- R4: The ID value is accepted only if (ID & 0x0FF00001) == 0x0BA00001. Otherwise the run stops with code 2.
- R5: The power write carries 0x50000000 (requests at bits 30 and 28). Polling continues until bits 31 and 29 both read 1.
- R6: The reset write carries 0x54000000 (bit 26 added). Polling continues until bits 31, 29 and 27 all read 1.
- R7: After the reset acknowledge, 0x50000000 is written to CTRL/STAT again.
- R8: Each poll issues at most POLL_LIMIT reads. An acknowledge on the last read still passes. Without one, the run stops with code 3 (power) or 4 (reset).
- R9: The port word from the read-buffer read is accepted only if bits [3:0] equal 1. Otherwise the run stops with code 5.
- R10: A request completed with txn_ok_i=0 stops the run with code 1, and no further request is issued.
- R11: When finished, done_o=1, busy_o=0 and txn_req_o=0. pass_o=1 exactly when the code is 0. These hold until a start.
- R12: start_i is ignored while busy. A start while finished reruns the whole sequence from the line-switch, with the code cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Rerun command, honoured when finished |
| txn_req_o | output | 1 | Request valid to the transaction engine |
| txn_kind_o | output | 2 | 0 line-switch, 1 read, 2 write |
| txn_ap_o | output | 1 | 1 = access-port register, 0 = debug-port register |
| txn_addr_o | output | 4 | Register address (bits 3:2 significant) |
| txn_wdata_o | output | 32 | Write data |
| txn_done_i | input | 1 | Engine completion pulse |
| txn_ok_i | input | 1 | Completion status, 1 = acknowledged |
| txn_rdata_i | input | 32 | Read data, valid with txn_done_i |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |
| pass_o | output | 1 | Finished without failure |
| fail_code_o | output | 3 | 0 none, 1 no target, 2 bad ID, 3 power timeout, 4 reset timeout, 5 wrong port |

## Verification
The bench builds the block with POLL_LIMIT=4. At that value both timeout codes are reached in a handful of polls, and an acknowledge on the fourth and final read tests the pass side of the same boundary. The default ID mask and port type are kept. Engine latencies of zero, one and two cycles exercise back-to-back acceptance and held requests. Failures are injected at the first request and in mid-sequence.

// File: rtl/dbg_bringup_pkg.sv
package dbg_bringup_pkg;

  typedef enum logic [1:0] {
    TXN_LINE_SW = 2'd0,
    TXN_READ    = 2'd1,
    TXN_WRITE   = 2'd2
  } txn_kind_e;

  typedef enum logic [2:0] {
    FC_NONE      = 3'd0,
    FC_NO_TARGET = 3'd1,
    FC_BAD_ID    = 3'd2,
    FC_PWR_TMO   = 3'd3,
    FC_RST_TMO   = 3'd4,
    FC_BAD_PORT  = 3'd5
  } fail_code_e;

  typedef enum logic [3:0] {
    ST_LINE_SW,
    ST_ID_RD,
    ST_PWR_WR,
    ST_PWR_POLL,
    ST_RST_WR,
    ST_RST_POLL,
    ST_RST_REL,
    ST_BANK_WR,
    ST_PORT_RD,
    ST_BUF_RD,
    ST_FINISH
  } step_e;

  typedef struct packed {
    txn_kind_e   kind;
    logic        ap;
    logic [3:0]  addr;
    logic [31:0] wdata;
  } txn_req_t;

  // control/status bit positions
  localparam int unsigned SYS_PWR_ACK_BIT = 31;
  localparam int unsigned SYS_PWR_REQ_BIT = 30;
  localparam int unsigned DBG_PWR_ACK_BIT = 29;
  localparam int unsigned DBG_PWR_REQ_BIT = 28;
  localparam int unsigned DBG_RST_ACK_BIT = 27;
  localparam int unsigned DBG_RST_REQ_BIT = 26;

  localparam logic [31:0] PWR_REQS = (32'd1 << SYS_PWR_REQ_BIT) | (32'd1 << DBG_PWR_REQ_BIT);
  localparam logic [31:0] RST_REQ  = 32'd1 << DBG_RST_REQ_BIT;
  localparam logic [31:0] PWR_ACKS = (32'd1 << SYS_PWR_ACK_BIT) | (32'd1 << DBG_PWR_ACK_BIT);
  localparam logic [31:0] RST_ACK  = 32'd1 << DBG_RST_ACK_BIT;

  localparam logic [3:0]  DP_ID_ADDR   = 4'h0;
  localparam logic [3:0]  DP_CTRL_ADDR = 4'h4;
  localparam logic [3:0]  DP_BANK_ADDR = 4'h8;
  localparam logic [3:0]  DP_BUF_ADDR  = 4'hC;
  localparam logic [3:0]  AP_ID_ADDR   = 4'hC;
  localparam logic [31:0] BANK_ID_SEL  = 32'h0000_00F0;

endpackage

// File: rtl/dbg_step_decode.sv
module dbg_step_decode
  import dbg_bringup_pkg::*;
(
  input  step_e    step_i,
  output txn_req_t req_o
);

  always_comb begin
    req_o = '{kind: TXN_READ, ap: 1'b0, addr: 4'h0, wdata: 32'h0};
    unique case (step_i)
      ST_LINE_SW:  req_o.kind = TXN_LINE_SW;
      ST_ID_RD:    req_o.addr = DP_ID_ADDR;
      ST_PWR_WR:   begin req_o.kind = TXN_WRITE; req_o.addr = DP_CTRL_ADDR; req_o.wdata = PWR_REQS; end
      ST_PWR_POLL: req_o.addr = DP_CTRL_ADDR;
      ST_RST_WR:   begin req_o.kind = TXN_WRITE; req_o.addr = DP_CTRL_ADDR; req_o.wdata = PWR_REQS | RST_REQ; end
      ST_RST_POLL: req_o.addr = DP_CTRL_ADDR;
      ST_RST_REL:  begin req_o.kind = TXN_WRITE; req_o.addr = DP_CTRL_ADDR; req_o.wdata = PWR_REQS; end
      ST_BANK_WR:  begin req_o.kind = TXN_WRITE; req_o.addr = DP_BANK_ADDR; req_o.wdata = BANK_ID_SEL; end
      ST_PORT_RD:  begin req_o.ap = 1'b1; req_o.addr = AP_ID_ADDR; end
      ST_BUF_RD:   req_o.addr = DP_BUF_ADDR;
      default:     req_o.kind = TXN_LINE_SW;
    endcase
  end

endmodule

// File: rtl/dbg_value_check.sv
module dbg_value_check
  import dbg_bringup_pkg::*;
#(
  parameter logic [31:0] ID_MASK   = 32'h0FF0_0001,
  parameter logic [31:0] ID_MATCH  = 32'h0BA0_0001,
  parameter logic [3:0]  PORT_TYPE = 4'h1
) (
  input  logic [31:0] rdata_i,
  output logic        id_ok_o,
  output logic        pwr_ok_o,
  output logic        rst_ok_o,
  output logic        port_ok_o
);

  localparam logic [31:0] RST_ALL = PWR_ACKS | RST_ACK;

  assign id_ok_o   = (rdata_i & ID_MASK) == (ID_MATCH & ID_MASK);
  assign pwr_ok_o  = (rdata_i & PWR_ACKS) == PWR_ACKS;
  assign rst_ok_o  = (rdata_i & RST_ALL) == RST_ALL;
  assign port_ok_o = rdata_i[3:0] == PORT_TYPE;

endmodule

// File: rtl/dbg_retry_ctr.sv
module dbg_retry_ctr #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = cnt_q == LAST;

  // R8: a poll counter never passes its last slot
  a_r8_ctr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !clear_i |=> last_o);

endmodule

// File: rtl/dbg_bringup_seq.sv
module dbg_bringup_seq
  import dbg_bringup_pkg::*;
#(
  parameter int unsigned POLL_LIMIT = 8,
  parameter logic [31:0] ID_MASK    = 32'h0FF0_0001,
  parameter logic [31:0] ID_MATCH   = 32'h0BA0_0001,
  parameter logic [3:0]  PORT_TYPE  = 4'h1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output logic        txn_req_o,
  output logic [1:0]  txn_kind_o,
  output logic        txn_ap_o,
  output logic [3:0]  txn_addr_o,
  output logic [31:0] txn_wdata_o,
  input  logic        txn_done_i,
  input  logic        txn_ok_i,
  input  logic [31:0] txn_rdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        pass_o,
  output logic [2:0]  fail_code_o
);

  step_e      state_q, state_d;
  fail_code_e fail_q, fail_d;
  txn_req_t   req;
  logic       id_ok, pwr_ok, rst_ok, port_ok;
  logic       cnt_clr, cnt_inc, cnt_last;

  dbg_step_decode u_decode (
    .step_i (state_q),
    .req_o  (req)
  );

  dbg_value_check #(
    .ID_MASK   (ID_MASK),
    .ID_MATCH  (ID_MATCH),
    .PORT_TYPE (PORT_TYPE)
  ) u_check (
    .rdata_i   (txn_rdata_i),
    .id_ok_o   (id_ok),
    .pwr_ok_o  (pwr_ok),
    .rst_ok_o  (rst_ok),
    .port_ok_o (port_ok)
  );

  dbg_retry_ctr #(.LIMIT(POLL_LIMIT)) u_retry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (cnt_clr),
    .inc_i   (cnt_inc),
    .last_o  (cnt_last)
  );

  always_comb begin
    state_d = state_q;
    fail_d  = fail_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    if (state_q == ST_FINISH) begin
      if (start_i) begin
        state_d = ST_LINE_SW;
        fail_d  = FC_NONE;
      end
    end else if (txn_done_i) begin
      if (!txn_ok_i) begin
        state_d = ST_FINISH;
        fail_d  = FC_NO_TARGET;
      end else begin
        unique case (state_q)
          ST_LINE_SW: state_d = ST_ID_RD;
          ST_ID_RD: begin
            if (id_ok) state_d = ST_PWR_WR;
            else begin state_d = ST_FINISH; fail_d = FC_BAD_ID; end
          end
          ST_PWR_WR: begin state_d = ST_PWR_POLL; cnt_clr = 1'b1; end
          ST_PWR_POLL: begin
            if (pwr_ok)        state_d = ST_RST_WR;
            else if (cnt_last) begin state_d = ST_FINISH; fail_d = FC_PWR_TMO; end
            else               cnt_inc = 1'b1;
          end
          ST_RST_WR: begin state_d = ST_RST_POLL; cnt_clr = 1'b1; end
          ST_RST_POLL: begin
            if (rst_ok)        state_d = ST_RST_REL;
            else if (cnt_last) begin state_d = ST_FINISH; fail_d = FC_RST_TMO; end
            else               cnt_inc = 1'b1;
          end
          ST_RST_REL: state_d = ST_BANK_WR;
          ST_BANK_WR: state_d = ST_PORT_RD;
          ST_PORT_RD: state_d = ST_BUF_RD;
          ST_BUF_RD: begin
            state_d = ST_FINISH;
            fail_d  = port_ok ? FC_NONE : FC_BAD_PORT;
          end
          default: state_d = ST_FINISH;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LINE_SW;
      fail_q  <= FC_NONE;
    end else begin
      state_q <= state_d;
      fail_q  <= fail_d;
    end
  end

  assign busy_o      = state_q != ST_FINISH;
  assign done_o      = state_q == ST_FINISH;
  assign pass_o      = done_o && fail_q == FC_NONE;
  assign fail_code_o = fail_q;
  assign txn_req_o   = busy_o;
  assign txn_kind_o  = req.kind;
  assign txn_ap_o    = req.ap;
  assign txn_addr_o  = req.addr;
  assign txn_wdata_o = req.wdata;

  // R2: request fields held until accepted
  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_req_o && !txn_done_i |=> txn_req_o && $stable(txn_kind_o) && $stable(txn_ap_o)
      && $stable(txn_addr_o) && $stable(txn_wdata_o));

  // R4: rejected ID ends the run with code 2
  a_r4_bad_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ID_RD && txn_done_i && txn_ok_i && !id_ok |=> done_o && fail_code_o == 3'd2);

  // R8: power timeout only reported from the power poll
  a_r8_pwr_tmo_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) && fail_code_o == 3'd3 |-> $past(state_q) == ST_PWR_POLL);

  // R9: final verdict follows the port-type check
  a_r9_port_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_BUF_RD && txn_done_i && txn_ok_i |=> done_o && pass_o == $past(port_ok));

  // R10: engine failure stops the run
  a_r10_fail_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && txn_done_i && !txn_ok_i |=> done_o && fail_code_o == 3'd1);

  // R11: finished state holds until a start
  a_r11_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(fail_code_o));

endmodule

// File: tb/dbg_bringup_seq_tb.sv
module dbg_bringup_seq_tb_top;

  localparam int LIM = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        txn_req_o;
  logic [1:0]  txn_kind_o;
  logic        txn_ap_o;
  logic [3:0]  txn_addr_o;
  logic [31:0] txn_wdata_o;
  logic        txn_done_i = 1'b0;
  logic        txn_ok_i = 1'b0;
  logic [31:0] txn_rdata_i = '0;
  logic        busy_o, done_o, pass_o;
  logic [2:0]  fail_code_o;

  always #10 clk_i = ~clk_i;

  dbg_bringup_seq #(.POLL_LIMIT(LIM)) dut_i (
    .clk_i, .rst_ni, .start_i, .txn_req_o, .txn_kind_o, .txn_ap_o, .txn_addr_o,
    .txn_wdata_o, .txn_done_i, .txn_ok_i, .txn_rdata_i, .busy_o, .done_o, .pass_o, .fail_code_o
  );

  typedef struct {
    logic [1:0]  kind;
    logic        ap;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        ok;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   lat     = 0;
  int   fail_at = -1;
  int   exp_code = 0;
  bit   stop;

  task automatic chk(input bit cond, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // reference model: expected request list and verdict
  task automatic add(input logic [1:0] k, input logic ap, input logic [3:0] a,
                     input logic [31:0] wd, input logic [31:0] rd, input string tag);
    exp_t e;
    e.kind = k; e.ap = ap; e.addr = a; e.wdata = wd; e.rdata = rd; e.tag = tag;
    e.ok = (exp_q.size() != fail_at);
    exp_q.push_back(e);
    if (!e.ok) begin stop = 1; exp_code = 1; end
  endtask

  task automatic build(input logic [31:0] id, input int pw, input int rw, input logic [31:0] idr);
    exp_q.delete(); stop = 0; exp_code = 0;
    add(2'd0, 0, 4'h0, 0, 0, "R1"); if (stop) return;
    add(2'd1, 0, 4'h0, 0, id, "R3"); if (stop) return;
    if ((id & 32'h0FF00001) != 32'h0BA00001) begin exp_code = 2; return; end
    add(2'd2, 0, 4'h4, 32'h50000000, 0, "R5"); if (stop) return;
    for (int i = 0; i < LIM; i++) begin
      add(2'd1, 0, 4'h4, 0, (i >= pw) ? 32'hF0000000 : 32'h50000000, "R5"); if (stop) return;
      if (i >= pw) break;
      if (i == LIM - 1) begin exp_code = 3; return; end
    end
    add(2'd2, 0, 4'h4, 32'h54000000, 0, "R6"); if (stop) return;
    for (int i = 0; i < LIM; i++) begin
      add(2'd1, 0, 4'h4, 0, (i >= rw) ? 32'hFC000000 : 32'hF4000000, "R6"); if (stop) return;
      if (i >= rw) break;
      if (i == LIM - 1) begin exp_code = 4; return; end
    end
    add(2'd2, 0, 4'h4, 32'h50000000, 0, "R7"); if (stop) return;
    add(2'd2, 0, 4'h8, 32'h000000F0, 0, "R3"); if (stop) return;
    add(2'd1, 1, 4'hC, 0, 32'hDEAD0000, "R3"); if (stop) return;
    add(2'd1, 0, 4'hC, 0, idr, "R9"); if (stop) return;
    exp_code = (idr[3:0] == 4'h1) ? 0 : 5;
  endtask

  // engine model, compares the presented request every clock
  initial begin
    int wcnt = 0;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin txn_done_i = 0; wcnt = 0; continue; end
      if (txn_done_i) begin txn_done_i = 0; wcnt = 0; end
      if (txn_req_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected request kind", {30'd0, txn_kind_o}, 32'hFFFFFFFF);
          txn_done_i = 1; txn_ok_i = 1; txn_rdata_i = 0;
        end else begin
          exp_t h;
          h = exp_q[0];
          chk(txn_kind_o == h.kind, h.tag, "kind (R2 hold)", {30'd0, txn_kind_o}, {30'd0, h.kind});
          if (h.kind != 2'd0) begin
            chk(txn_ap_o == h.ap && txn_addr_o == h.addr, h.tag, "ap/addr",
                {27'd0, txn_ap_o, txn_addr_o}, {27'd0, h.ap, h.addr});
          end
          if (h.kind == 2'd2) chk(txn_wdata_o == h.wdata, h.tag, "wdata", txn_wdata_o, h.wdata);
          if (wcnt >= lat) begin
            txn_done_i = 1; txn_ok_i = h.ok; txn_rdata_i = h.rdata;
            void'(exp_q.pop_front());
          end else wcnt++;
        end
      end
    end
  end

  task automatic run_wait(input string tag);
    int n = 0;
    while (!done_o && n < 3000) begin @(negedge clk_i); n++; end
    chk(done_o, tag, "done", {31'd0, done_o}, 1);
    chk(exp_q.size() == 0, tag, "requests left", exp_q.size(), 0);
    chk(fail_code_o == exp_code[2:0], tag, "fail code", {29'd0, fail_code_o}, exp_code);
    chk(pass_o == (exp_code == 0), "R11", "pass", {31'd0, pass_o}, {31'd0, exp_code == 0});
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(done_o && !busy_o && !txn_req_o, "R11", "idle hold",
          {29'd0, done_o, busy_o, txn_req_o}, 32'h4);
    end
  endtask

  task automatic kick();
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
    chk(busy_o && txn_req_o && txn_kind_o == 2'd0, "R12", "restart from line-switch",
        {29'd0, busy_o, txn_req_o, txn_kind_o == 2'd0}, 32'h7);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // S1: nominal, zero latency, started by reset
    lat = 0; fail_at = -1;
    build(32'h2BA01477, 0, 0, 32'h24770011);
    #5;
    chk(busy_o && !done_o && txn_req_o && txn_kind_o == 2'd0, "R1", "reset state",
        {28'd0, busy_o, done_o, txn_req_o, txn_kind_o == 2'd0}, 32'hB);
    @(negedge clk_i); rst_ni = 1;
    chk(busy_o && txn_req_o && txn_kind_o == 2'd0, "R1", "first cycle",
        {29'd0, busy_o, txn_req_o, txn_kind_o == 2'd0}, 32'h7);
    run_wait("R3");

    // S2: acks on last poll, latency 2, start pulse while busy
    lat = 2;
    build(32'h1BA00477, 3, 3, 32'h14770001);
    kick();
    repeat (6) @(negedge clk_i);
    start_i = 1; @(negedge clk_i); start_i = 0;
    chk(busy_o, "R12", "start while busy", {31'd0, busy_o}, 1);
    run_wait("R8");

    // S3: ID rejected
    lat = 1;
    build(32'h4BA00476, 0, 0, 32'h1); kick(); run_wait("R4");
    // S3b: top nibble of ID ignored
    build(32'hFBA00001, 0, 0, 32'h1); kick(); run_wait("R4");

    // S4: power acknowledge never arrives
    build(32'h2BA01477, 4, 0, 32'h1); kick(); run_wait("R8");
    // S5: reset acknowledge never arrives
    build(32'h2BA01477, 1, 9, 32'h1); kick(); run_wait("R8");
    // S6: wrong port type
    build(32'h2BA01477, 0, 0, 32'h24770012); kick(); run_wait("R9");

    // S7/S8: engine failure at start and mid-sequence
    lat = 0; fail_at = 0;
    build(32'h2BA01477, 0, 0, 32'h1); kick(); run_wait("R10");
    fail_at = 6;
    build(32'h2BA01477, 2, 0, 32'h1); kick(); run_wait("R10");

    // S9: clean rerun after failure
    fail_at = -1; lat = 1;
    build(32'h0BA00001, 1, 2, 32'hFFFFFFF1); kick(); run_wait("R12");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule